// File: doc/BRIEF.md
# Filtered Power-On Reset Supervisor

This block turns one "rail good" comparator bit into an active-low reset for the logic that depends on that rail. The comparator bit is high while the monitored supply sits above 90% of its nominal level. It arrives asynchronously, so the block first passes it through a two-flop synchronizer. A saturating up/down integrator then filters it. Short dips and spikes only move the integrator part of the way, so they never reach the reset output. A disturbance has to be deep and long enough to drain or fill the integrator before the reset output changes.

When the filtered level turns good, a release timer starts. The reset output is deasserted only after the timer has counted its full timeout. When the filtered level turns bad, reset is asserted on the next clock and held. If this happens while the timer is still counting, the timer is cleared, and the next good crossing runs the full delay again. The timeout is a parameter by default. A nonzero value on an input port replaces it, and that value is captured while the filtered level is bad.

Top module: `por_supervisor`

## Requirements
- R1: A synchronous reset (`rst` high) drives `por_n` low from the next clock edge, empties the integrator, clears the synchronizer and clears the release timer.
- R2: `rail_ok_async` passes through two flip-flops before it reaches the integrator. A level driven before clock edge 1 first moves the integrator at edge 3.
- R3: The integrator is a counter that saturates at both ends, 0 and `FILT_LIMIT`. It counts up on each cycle the synchronized bit is 1 and down on each cycle it is 0. The filtered level turns good in the cycle the counter reaches `FILT_LIMIT`.
- R4: The filtered level turns bad in the cycle the counter reaches 0. `por_n` is low from the following edge and stays low while the filtered level is bad.
- R5: `por_n` goes high exactly T edges after the filtered level turned good, where T is the latched timeout (T >= 1).
- R6: A dip that does not drain the integrator to 0 leaves `por_n` unchanged. A running release timer keeps counting through such a dip.
- R7: If the filtered level turns bad before release, the timer is cleared. The next release again needs the full T edges of filtered-good level.
- R8: While the filtered level is bad, T is latched from `rel_cycles`. The value 0 selects the parameter `REL_DEFAULT`. Changes to `rel_cycles` while the filtered level is good have no effect on the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok_async | input | 1 | Asynchronous comparator bit, 1 = rail above threshold |
| rel_cycles | input | REL_W | Release timeout override in cycles, 0 = use `REL_DEFAULT` |
| por_n | output | 1 | Registered active-low reset output |

## Verification
The assertions assume that `rel_cycles` never yields a timeout of zero and that `REL_DEFAULT` is at least 1. Under that assumption, a release always follows at least one cycle of good filtered level. The bench only drives `rail_ok_async` and `rel_cycles` on falling clock edges. It holds every level for a known number of edges, so the integrator and timer counts can be computed exactly. This includes dips that stop one count short of emptying the integrator. The only out-of-band event is a synchronous reset, applied while the output is released.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic {
    RAIL_BAD  = 1'b0,
    RAIL_GOOD = 1'b1
  } rail_lvl_e;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  assign d_sync = sh[STAGES-1];

endmodule

// File: rtl/por_integrator.sv
module por_integrator
  import por_pkg::*;
#(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic in_good,
  output logic filt_good
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt, cnt_nx;
  rail_lvl_e     lvl;

  always_comb begin
    cnt_nx = cnt;
    if (in_good) begin
      if (cnt != LIM_V) cnt_nx = cnt + 1'b1;
    end else begin
      if (cnt != '0) cnt_nx = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= RAIL_BAD;
    end else begin
      cnt <= cnt_nx;
      if (cnt_nx == LIM_V)   lvl <= RAIL_GOOD;
      else if (cnt_nx == '0) lvl <= RAIL_BAD;
    end
  end

  assign filt_good = (lvl == RAIL_GOOD);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_V);

  // R3
  good_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_good) |-> (cnt == LIM_V));

  // R4
  bad_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(filt_good) |-> (cnt == '0));

endmodule

// File: rtl/por_release_timer.sv
module por_release_timer #(
  parameter int REL_W       = 16,
  parameter int REL_DEFAULT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             filt_good,
  input  logic [REL_W-1:0] rel_cfg,
  output logic             rst_n_q
);

  localparam logic [REL_W-1:0] DEF_V = REL_W'(REL_DEFAULT);

  logic [REL_W-1:0] elapsed;
  logic [REL_W-1:0] tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      rst_n_q <= 1'b0;
      tmo     <= DEF_V;
    end else if (!filt_good) begin
      elapsed <= '0;
      rst_n_q <= 1'b0;
      tmo     <= (rel_cfg == '0) ? DEF_V : rel_cfg;
    end else if (!rst_n_q) begin
      elapsed <= elapsed + 1'b1;
      if (elapsed + 1'b1 == tmo) rst_n_q <= 1'b1;
    end
  end

  // R4
  bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !filt_good |=> !rst_n_q);

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(filt_good) |=> (elapsed == '0));

  // R5
  release_good_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> $past(filt_good));

endmodule

// File: rtl/por_supervisor.sv
module por_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LIMIT  = 64,
  parameter int REL_W       = 16,
  parameter int REL_DEFAULT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rail_ok_async,
  input  logic [REL_W-1:0] rel_cycles,
  output logic             por_n
);

  logic rail_sync;
  logic filt_good;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rail_ok_async),
    .d_sync  (rail_sync)
  );

  por_integrator #(.LIMIT(FILT_LIMIT)) u_integ (
    .clk       (clk),
    .rst       (rst),
    .in_good   (rail_sync),
    .filt_good (filt_good)
  );

  por_release_timer #(.REL_W(REL_W), .REL_DEFAULT(REL_DEFAULT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .filt_good (filt_good),
    .rel_cfg   (rel_cycles),
    .rst_n_q   (por_n)
  );

  // R1
  por_on_reset_chk: assert property (@(posedge clk)
    rst |=> !por_n);

endmodule

// File: tb/por_supervisor_bench.sv
`timescale 1ns/1ps
module por_supervisor_bench;

  localparam int LIM  = 8;
  localparam int RW   = 8;
  localparam int TDEF = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rail = 1'b0;
  logic [RW-1:0] cfg = '0;
  logic          por_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  por_supervisor #(
    .SYNC_STAGES(2), .FILT_LIMIT(LIM), .REL_W(RW), .REL_DEFAULT(TDEF)
  ) u_por_supervisor (
    .clk(clk), .rst(rst), .rail_ok_async(rail), .rel_cycles(cfg), .por_n(por_n)
  );

  // {level, edges to hold, expected por_n, requirement number}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'd29, 1'b0, 5'd5},  // R5 one edge before release
    {1'b1, 8'd1,  1'b1, 5'd5},  // R5 release edge
    {1'b0, 8'd5,  1'b1, 5'd6},  // R6 short dip
    {1'b1, 8'd10, 1'b1, 5'd6},  // R6 refill
    {1'b0, 8'd9,  1'b1, 5'd3},  // R3 integrator drains to 1
    {1'b0, 8'd1,  1'b1, 5'd2},  // R2 reaches 0, output one edge later
    {1'b0, 8'd1,  1'b0, 5'd4},  // R4 asserted
    {1'b1, 8'd25, 1'b0, 5'd3},  // R3 refill from 0, timer running
    {1'b0, 8'd4,  1'b0, 5'd6},  // R6 dip while timer runs
    {1'b1, 8'd1,  1'b1, 5'd6},  // R6 timer kept counting
    {1'b0, 8'd12, 1'b0, 5'd4},  // R4 brownout
    {1'b1, 8'd15, 1'b0, 5'd7},  // R7 timer partly run
    {1'b0, 8'd10, 1'b0, 5'd7},  // R7 abort
    {1'b1, 8'd25, 1'b0, 5'd7},  // R7 no credit from earlier run
    {1'b1, 8'd5,  1'b1, 5'd7}   // R7 full delay then release
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (por_n !== exp) begin
      errors++;
      $display("FAIL R%0d %s: por_n=%b expected=%b", req, what, por_n, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1, "reset state"); // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      rail = VEC[i][14];
      hold(int'(VEC[i][13:6]));
      check(VEC[i][5], int'(VEC[i][4:0]), $sformatf("vector %0d", i));
    end

    // R1 reset while released
    rst = 1'b1;
    hold(1);
    check(1'b0, 1, "reset mid-run");

    // R8 port timeout of 3 latched while filtered level is bad
    rail = 1'b0;
    cfg  = 8'd3;
    hold(2);
    rst  = 1'b0;
    rail = 1'b1;
    hold(11);
    cfg = 8'd50; // R8 change while filtered good must be ignored
    hold(1);
    check(1'b0, 8, "port timeout, one before release");
    hold(1);
    check(1'b1, 8, "port timeout release, late change ignored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule